// File: doc/BRIEF.md
# I2C Byte Command Sequencer

This block sits between a register front end and a bit timing controller of an I2C master. It takes one command word and expands it into an ordered stream of bit-level commands (start condition, stop condition, write one bit, read one bit). The bit timing controller acknowledges each of these in turn. A single command word may chain a start (or repeated start), one byte transfer with its acknowledge slot, and a stop. Each byte becomes exactly eight bit commands, followed by one acknowledge bit command.

For a byte write, the transmit byte goes out most significant bit first. One more bit is then read back and kept as the slave's acknowledge. For a byte read, eight bits are shifted into the receive byte most significant bit first. The acknowledge value from the command word is then driven in the acknowledge slot. `busy` covers the whole command, and `done` pulses for one cycle when the command completes or is aborted by lost arbitration.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rx_ack` and `rx_byte` are 0 and `bit_cmd` is 0 (no operation).
- R2: The command word is `cmd_word[7]` start, `[6]` stop, `[5]` read, `[4]` write and `[3]` acknowledge value sent after a read (1 = not acknowledge). It is taken on a `cmd_valid` cycle while idle if at least one of bits 7..4 is set, and `busy` is 1 from the next cycle. A `cmd_valid` while busy is ignored and leaves the running bit command stream unchanged.
- R3: `bit_cmd` encodes 0 = none, 1 = start, 2 = stop, 3 = write bit, 4 = read bit. A command with the start flag issues a start first. This includes a start given while the previous transaction was left open without a stop, which acts as a repeated start.
- R4: A write issues eight write-bit commands, and `bit_dout` carries the bits of `tx_byte` from bit 7 down to bit 0.
- R5: After the eighth written bit, one read-bit command follows, and the `bit_din` returned with its acknowledge is presented on `rx_ack` at completion.
- R6: A read issues eight read-bit commands, and the returned bits form `rx_byte` with the first bit in bit 7.
- R7: After the eighth read bit, one write-bit command follows whose `bit_dout` equals `cmd_word[3]`.
- R8: With the stop flag set, a stop command is issued last. A command holding only the stop flag issues only a stop.
- R9: Each bit command stays on `bit_cmd` until the cycle `bit_ack` is high, and the following one appears in the next cycle.
- R10: On completion `done` is high for exactly one cycle, and `busy` falls in that same cycle.
- R11: `arb_lost` while busy ends the command in the next cycle: `done` pulses, `busy` falls, `bit_cmd` returns to 0, and no pending stop or bit is issued afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 5 | Command flags, bits 7..3 |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Last byte received |
| rx_ack | output | 1 | Acknowledge bit read after the last write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_cmd | output | 3 | Bit command to the bit timing controller |
| bit_dout | output | 1 | Bit value for a write-bit command |
| bit_ack | input | 1 | Bit controller finished the current bit command |
| bit_din | input | 1 | Bit sampled by the bit controller, valid with `bit_ack` |
| arb_lost | input | 1 | Bit controller lost arbitration |

## Verification
The bench goes after three areas.

- **Acknowledge slot and bit order.** It checks the direction of the acknowledge slot after writes and after reads, and that read bits and written bits keep their order. A design that swaps the slot direction would produce a write where a read is expected, and the scoreboard would catch the mismatch. A design that reverses bit order would return a mirrored receive byte.
- **Ignored command word and repeated start.** It pokes a stop-only command word into a running write. A design that does not ignore it would insert an extra stop. It also issues a start while a transaction is still open, and a design that skipped the repeated start would miss the leading start command.
- **Arbitration loss.** It drops arbitration in the middle of a byte that has a stop pending. A design that kept going would go on issuing bits or a stop. A design that forgot to pulse `done` would leave the waiting side hung.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [2:0] {
      BC_NOP   = 3'd0,
      BC_START = 3'd1,
      BC_STOP  = 3'd2,
      BC_WRITE = 3'd3,
      BC_READ  = 3'd4
   } bit_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_XFER,
      S_ACK,
      S_STOP
   } seq_state_e;

   // command word flag positions
   localparam int CW_START = 7;
   localparam int CW_STOP  = 6;
   localparam int CW_READ  = 5;
   localparam int CW_WRITE = 4;
   localparam int CW_NACK  = 3;

endpackage

// File: rtl/i2c_seq_bitcnt.sv
module i2c_seq_bitcnt #(
   parameter int COUNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CNT_W = (COUNT > 1) ? $clog2(COUNT) : 1;
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(COUNT - 1);

   if (COUNT < 2) begin : g_bad_count
      $error("i2c_seq_bitcnt: COUNT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign last = (cnt_q == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_seq_shreg.sv
module i2c_seq_shreg #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sin,
   output logic [W-1:0] nxt,
   output logic         sout
);
   if (W < 2) begin : g_bad_width
      $error("i2c_seq_shreg: W must be at least 2");
   end

   logic [W-1:0] sr_q;

   if (MSB_FIRST) begin : g_msb
      assign nxt  = {sr_q[W-2:0], sin};
      assign sout = sr_q[W-1];
   end else begin : g_lsb
      assign nxt  = {sin, sr_q[W-1:1]};
      assign sout = sr_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else if (shift) begin
         sr_q <= nxt;
      end
   end
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
   import i2c_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:3]        cmd_word,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_ack,
   output logic              busy,
   output logic              done,
   output logic [2:0]        bit_cmd,
   output logic              bit_dout,
   input  logic              bit_ack,
   input  logic              bit_din,
   input  logic              arb_lost
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("i2c_byte_seq: DATA_W must be at least 2");
   end

   seq_state_e        state_q;
   bit_cmd_e          bcmd_q;
   logic              busy_q, done_q, ack_q;
   logic              f_stop_q, f_rd_q, f_wr_q, f_nack_q;
   logic [DATA_W-1:0] rx_q;

   logic              any_flag, accept, abort, step;
   logic              sh_shift, last_bit, sh_sout;
   logic [DATA_W-1:0] sh_nxt;

   assign any_flag = cmd_word[CW_START] | cmd_word[CW_STOP]
                   | cmd_word[CW_READ]  | cmd_word[CW_WRITE];
   assign accept   = (state_q == S_IDLE) && cmd_valid && any_flag;
   assign abort    = (state_q != S_IDLE) && arb_lost;
   assign step     = bit_ack && !abort;
   assign sh_shift = (state_q == S_XFER) && step;

   i2c_seq_shreg #(.W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (tx_byte),
      .shift    (sh_shift),
      .sin      (bit_din),
      .nxt      (sh_nxt),
      .sout     (sh_sout)
   );

   i2c_seq_bitcnt #(.COUNT(DATA_W)) u_bitcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (abort | accept),
      .inc   (sh_shift),
      .last  (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         bcmd_q   <= BC_NOP;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         ack_q    <= 1'b0;
         rx_q     <= '0;
         f_stop_q <= 1'b0;
         f_rd_q   <= 1'b0;
         f_wr_q   <= 1'b0;
         f_nack_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            state_q  <= S_IDLE;
            bcmd_q   <= BC_NOP;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            f_stop_q <= 1'b0;
            f_rd_q   <= 1'b0;
            f_wr_q   <= 1'b0;
            f_nack_q <= 1'b0;
         end else begin
            unique case (state_q)
               S_IDLE: begin
                  if (accept) begin
                     busy_q   <= 1'b1;
                     f_stop_q <= cmd_word[CW_STOP];
                     f_rd_q   <= cmd_word[CW_READ];
                     f_wr_q   <= cmd_word[CW_WRITE] & ~cmd_word[CW_READ];
                     f_nack_q <= cmd_word[CW_NACK];
                     if (cmd_word[CW_START]) begin
                        state_q <= S_START;
                        bcmd_q  <= BC_START;
                     end else if (cmd_word[CW_READ] | cmd_word[CW_WRITE]) begin
                        state_q <= S_XFER;
                        bcmd_q  <= cmd_word[CW_READ] ? BC_READ : BC_WRITE;
                     end else begin
                        state_q <= S_STOP;
                        bcmd_q  <= BC_STOP;
                     end
                  end
               end
               S_START: begin
                  if (step) begin
                     if (f_rd_q | f_wr_q) begin
                        state_q <= S_XFER;
                        bcmd_q  <= f_rd_q ? BC_READ : BC_WRITE;
                     end else if (f_stop_q) begin
                        state_q <= S_STOP;
                        bcmd_q  <= BC_STOP;
                     end else begin
                        state_q <= S_IDLE;
                        bcmd_q  <= BC_NOP;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                     end
                  end
               end
               S_XFER: begin
                  if (step && last_bit) begin
                     if (f_rd_q) begin
                        rx_q <= sh_nxt;
                     end
                     state_q <= S_ACK;
                     bcmd_q  <= f_rd_q ? BC_WRITE : BC_READ;
                  end
               end
               S_ACK: begin
                  if (step) begin
                     if (f_wr_q) begin
                        ack_q <= bit_din;
                     end
                     if (f_stop_q) begin
                        state_q <= S_STOP;
                        bcmd_q  <= BC_STOP;
                     end else begin
                        state_q <= S_IDLE;
                        bcmd_q  <= BC_NOP;
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                     end
                  end
               end
               S_STOP: begin
                  if (step) begin
                     state_q <= S_IDLE;
                     bcmd_q  <= BC_NOP;
                     busy_q  <= 1'b0;
                     done_q  <= 1'b1;
                  end
               end
               default: begin
                  state_q <= S_IDLE;
                  bcmd_q  <= BC_NOP;
                  busy_q  <= 1'b0;
               end
            endcase
         end
      end
   end

   assign bit_cmd  = bcmd_q;
   assign bit_dout = (state_q == S_ACK) ? f_nack_q : sh_sout;
   assign rx_byte  = rx_q;
   assign rx_ack   = ack_q;
   assign busy     = busy_q;
   assign done     = done_q;
endmodule

// File: rtl/i2c_byte_seq_chk.sv
module i2c_byte_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic [2:0] bit_cmd,
   input logic       bit_ack,
   input logic       arb_lost
);
   // R1
   idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bit_cmd == 3'd0);

   // R9
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && !$past(bit_ack)) |-> $stable(bit_cmd));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11
   arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && arb_lost) |=> (done && !busy && bit_cmd == 3'd0));
endmodule

bind i2c_byte_seq i2c_byte_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .bit_cmd  (bit_cmd),
   .bit_ack  (bit_ack),
   .arb_lost (arb_lost)
);

// File: tb/tb_i2c_byte_seq.sv
`timescale 1ns/1ps
module tb_i2c_byte_seq;

   typedef struct packed {
      logic [2:0] cmd;
      logic       dout;
      logic       din;
   } item_t;

   localparam int LAT = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:3] cmd_word = '0;
   logic [7:0] tx_byte = '0;
   logic [7:0] rx_byte;
   logic       rx_ack, busy, done, bit_dout;
   logic [2:0] bit_cmd;
   logic       bit_ack = 1'b0;
   logic       bit_din = 1'b0;
   logic       arb_lost = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int wait_cnt = 0;
   bit finished = 1'b0;
   item_t exp_q[$];

   always #4 clk = ~clk;

   i2c_byte_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_ack(rx_ack), .busy(busy),
      .done(done), .bit_cmd(bit_cmd), .bit_dout(bit_dout), .bit_ack(bit_ack),
      .bit_din(bit_din), .arb_lost(arb_lost)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // bit controller responder and scoreboard monitor
   always @(negedge clk) begin
      bit_ack <= 1'b0;
      if (!rst_n || bit_cmd == 3'd0) begin
         wait_cnt <= 0;
      end else if (!bit_ack) begin
         if (wait_cnt == LAT) begin
            wait_cnt <= 0;
            bit_ack  <= 1'b1;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected bit command", int'(bit_cmd), 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               bit_din <= it.din;
               check(bit_cmd == it.cmd, "R3/R8 bit command order", int'(bit_cmd), int'(it.cmd));
               if (it.cmd == 3'd3)
                  check(bit_dout == it.dout, "R4/R7 written bit value", int'(bit_dout), int'(it.dout));
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   task automatic push_expected(input logic [7:3] cw, input logic [7:0] tx,
                                input logic [7:0] rd, input logic sack);
      if (cw[7]) exp_q.push_back('{cmd:3'd1, dout:1'b0, din:1'b0});
      if (cw[5]) begin
         for (int i = 7; i >= 0; i--) exp_q.push_back('{cmd:3'd4, dout:1'b0, din:rd[i]});
         exp_q.push_back('{cmd:3'd3, dout:cw[3], din:1'b0});
      end else if (cw[4]) begin
         for (int i = 7; i >= 0; i--) exp_q.push_back('{cmd:3'd3, dout:tx[i], din:1'b0});
         exp_q.push_back('{cmd:3'd4, dout:1'b0, din:sack});
      end
      if (cw[6]) exp_q.push_back('{cmd:3'd2, dout:1'b0, din:1'b0});
   endtask

   task automatic run_cmd(input logic [7:3] cw, input logic [7:0] tx,
                          input logic [7:0] rd, input logic sack, input bit poke,
                          input string tag);
      int n;
      push_expected(cw, tx, rd, sack);
      @(negedge clk);
      cmd_word  = cw;
      tx_byte   = tx;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
      n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
         if (poke && n == 5) begin cmd_word = 5'b01000; cmd_valid = 1'b1; end
         if (poke && n == 6) cmd_valid = 1'b0;
      end
      check(done == 1'b1, {tag, " R10 done seen"}, int'(done), 1);
      check(busy == 1'b0, {tag, " R10 busy low with done"}, int'(busy), 0);
      check(exp_q.size() == 0, {tag, " R2/R9 all bit commands issued"}, exp_q.size(), 0);
      if (cw[5]) check(rx_byte == rd, {tag, " R6 rx_byte"}, int'(rx_byte), int'(rd));
      if (cw[4] && !cw[5]) check(rx_ack == sack, {tag, " R5 rx_ack"}, int'(rx_ack), int'(sack));
      @(negedge clk);
      check(done == 1'b0, {tag, " R10 done one cycle"}, int'(done), 0);
      exp_q.delete();
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0, "R1 busy", int'(busy), 0);
      check(done == 0, "R1 done", int'(done), 0);
      check(bit_cmd == 0, "R1 bit_cmd", int'(bit_cmd), 0);
      check(rx_byte == 0, "R1 rx_byte", int'(rx_byte), 0);
      check(rx_ack == 0, "R1 rx_ack", int'(rx_ack), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_cmd(5'b10010, 8'h20, 8'h00, 1'b0, 1'b0, "R3 start+write");
      run_cmd(5'b00010, 8'h01, 8'h00, 1'b0, 1'b0, "R4 write");
      run_cmd(5'b01010, 8'hA5, 8'h00, 1'b1, 1'b0, "R8 write+stop nack");
      run_cmd(5'b10010, 8'h20, 8'h00, 1'b0, 1'b0, "R3 start+write");
      run_cmd(5'b10010, 8'h21, 8'h00, 1'b0, 1'b0, "R3 repeated start");
      run_cmd(5'b00100, 8'h00, 8'hA5, 1'b0, 1'b0, "R7 read ack");
      run_cmd(5'b01101, 8'h00, 8'h5A, 1'b0, 1'b0, "R7 read nack+stop");
      run_cmd(5'b01000, 8'h00, 8'h00, 1'b0, 1'b0, "R8 stop alone");
      run_cmd(5'b00010, 8'h3C, 8'h00, 1'b1, 1'b1, "R2 ignored poke");

      // R11 arbitration loss mid-byte with stop pending
      push_expected(5'b11010, 8'hC3, 8'h00, 1'b0);
      @(negedge clk);
      cmd_word = 5'b11010; tx_byte = 8'hC3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (12) @(negedge clk);
      arb_lost = 1'b1;
      @(negedge clk);
      arb_lost = 1'b0;
      check(done == 1'b1, "R11 done after arb loss", int'(done), 1);
      check(busy == 1'b0, "R11 busy low after arb loss", int'(busy), 0);
      check(bit_cmd == 3'd0, "R11 bit_cmd none after arb loss", int'(bit_cmd), 0);
      exp_q.delete();
      begin
         bit quiet;
         quiet = 1'b1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bit_cmd != 3'd0 || busy) quiet = 1'b0;
         end
         check(quiet, "R11 no further bit commands", int'(quiet), 1);
      end
      run_cmd(5'b01000, 8'h00, 8'h00, 1'b0, 1'b0, "R11 recovery stop");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule